// File: doc/BRIEF.md
# SD Card SPI Master with Bus Release

This block is a mode-0 SPI master for an SD card operated in SPI mode. Each command moves one word of either 8 or 32 bits, full duplex and most significant bit first, and gathers the card's answer into a reply word. A receive-only command keeps the outgoing data line high for the whole word, so the card sees all ones.

A separate release command frees the bus. It raises chip select and clocks a parameterised number of idle cycles with the data line high. It then removes the drive from chip select, clock and data-in, so a card that holds its data-out line can let it go. Until the next transfer command the pins stay undriven. That command drives them again, with the clock low and chip select low, before the first bit.

Each bit has a low clock phase of `SETUP_CYC` system cycles, during which the new outgoing bit is presented. It is followed by a high phase of `HOLD_CYC` cycles. The incoming bit is taken at the end of the high phase.

Top module: `sdspi_link`

## Requirements
- R1: After reset, `sclk_oe`, `mosi_oe` and `csn_oe` are 0, `busy` and `done` are 0, and `rx_word` is 0.
- R2: Outgoing bits leave most significant first. `mosi_o` holds the current bit for the whole of its low and high clock phases and does not change while `sclk_o` is high.
- R3: Each bit has two phases. `sclk_o` is low for `SETUP_CYC` cycles and then high for `HOLD_CYC` cycles, and `miso_i` is sampled at the clock edge that ends the high phase. `sclk_o` is low whenever `busy` is low.
- R4: With `cmd_long`=1 a command moves 32 bits taken from `tx_word[31:0]`. With `cmd_long`=0 it moves 8 bits taken from `tx_word[7:0]`, and `rx_word[31:8]` reads 0 at completion.
- R5: Received bits enter the reply from the least significant end, so the first bit sampled ends up at bit 31 (long) or bit 7 (byte) of `rx_word`.
- R6: `cmd_op`=1 (receive-only) drives `mosi_o` high for every bit. `cmd_op`=0 and `cmd_op`=3 both send `tx_word`.
- R7: `busy` rises in the cycle after an accepted start. In the cycle after the last sampling edge, `done` is high for exactly one cycle with `rx_word` valid, and `busy` is low in that cycle. A `cmd_start` that arrives while `busy` is high is ignored.
- R8: During a transfer (`cmd_op` 0, 1 or 3), and while idle between transfers, `csn_o` is 0 and `csn_oe` is 1.
- R9: `cmd_op`=2 (release) drives `csn_o` high and clocks `RELEASE_CLKS` bits with `mosi_o` high. In the `done` cycle all three output enables are 0, and `rx_word` keeps its earlier value.
- R10: After a release, the output enables stay 0 until the next transfer command. In the cycle after that command is accepted, all enables are 1, `csn_o` is 0 and `sclk_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start request, accepted when `busy` is low |
| cmd_op | input | 2 | 0/3 exchange, 1 receive-only, 2 release |
| cmd_long | input | 1 | 1 = 32-bit word, 0 = 8-bit word |
| tx_word | input | WORD_W | Word to transmit |
| rx_word | output | WORD_W | Reply word |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | Command in progress |
| sclk_o | output | 1 | Card clock |
| sclk_oe | output | 1 | Card clock drive enable |
| mosi_o | output | 1 | Card data-in line |
| mosi_oe | output | 1 | Card data-in drive enable |
| miso_i | input | 1 | Card data-out line |
| csn_o | output | 1 | Card chip select, active low |
| csn_oe | output | 1 | Chip select drive enable |

## Verification
The bench builds the block with `SETUP_CYC`=2 and `HOLD_CYC`=3, so the two clock phases differ in length and a swapped phase shows up in the cycle-by-cycle clock check. `RELEASE_CLKS` is set to 3 rather than the default 8. This shows that the release length follows the parameter and is independent of the word size, and it keeps release runs short enough to check every cycle. The bench compares clock level, data-out and chip select on every cycle of sweeps over byte and long patterns in each command mode. It also injects a second start in the middle of a transfer and runs a release followed by transfers.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;
   typedef enum logic [1:0] {
      OP_XCHG    = 2'd0,
      OP_RECV    = 2'd1,
      OP_RELEASE = 2'd2,
      OP_XCHG2   = 2'd3
   } sd_op_e;
endpackage

// File: rtl/sdspi_phase_timer.sv
module sdspi_phase_timer #(
   parameter int SETUP_CYC = 2,
   parameter int HOLD_CYC  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sck_hi,
   output logic bit_end
);
   localparam int MAXC = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
   localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
   localparam logic [CW-1:0] LO_LAST = CW'(SETUP_CYC - 1);
   localparam logic [CW-1:0] HI_LAST = CW'(HOLD_CYC - 1);

   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("SETUP_CYC must be at least 1");
   end
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("HOLD_CYC must be at least 1");
   end

   logic [CW-1:0] cnt;

   assign bit_end = run && sck_hi && (cnt == HI_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         sck_hi <= 1'b0;
      end else if (!run) begin
         cnt    <= '0;
         sck_hi <= 1'b0;
      end else if (!sck_hi && cnt == LO_LAST) begin
         cnt    <= '0;
         sck_hi <= 1'b1;
      end else if (bit_end) begin
         cnt    <= '0;
         sck_hi <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R3: high phase is entered only from the last cycle of a low phase
   p_low_before_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_hi) |-> $past(run));
endmodule

// File: rtl/sdspi_shifter.sv
module sdspi_shifter #(
   parameter int MAX_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [MAX_W-1:0] load_word,
   input  logic             clr_rx,
   input  logic             shift,
   input  logic             cap_en,
   input  logic             miso,
   output logic             mosi_bit,
   output logic [MAX_W-1:0] rx_word
);
   if (MAX_W < 8) begin : g_bad_width
      $error("MAX_W must be at least 8");
   end

   logic [MAX_W-1:0] tx_sr;

   assign mosi_bit = tx_sr[MAX_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_sr   <= '1;
         rx_word <= '0;
      end else begin
         if (load)       tx_sr <= load_word;
         else if (shift) tx_sr <= {tx_sr[MAX_W-2:0], 1'b1};
         if (clr_rx)               rx_word <= '0;
         else if (shift && cap_en) rx_word <= {rx_word[MAX_W-2:0], miso};
      end
   end

   // R9: a shift with capture disabled leaves the reply untouched
   p_reply_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !cap_en && !clr_rx) |=> $stable(rx_word));
endmodule

// File: rtl/sdspi_link.sv
module sdspi_link
   import sdspi_pkg::*;
#(
   parameter int WORD_W       = 32,
   parameter int BYTE_W       = 8,
   parameter int SETUP_CYC    = 2,
   parameter int HOLD_CYC     = 3,
   parameter int RELEASE_CLKS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic [1:0]        cmd_op,
   input  logic              cmd_long,
   input  logic [WORD_W-1:0] tx_word,
   output logic [WORD_W-1:0] rx_word,
   output logic              done,
   output logic              busy,
   output logic              sclk_o,
   output logic              sclk_oe,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              miso_i,
   output logic              csn_o,
   output logic              csn_oe
);
   localparam int CNT_MAX = (WORD_W > RELEASE_CLKS) ? WORD_W : RELEASE_CLKS;
   localparam int BCW     = $clog2(CNT_MAX + 1);

   if (WORD_W <= BYTE_W) begin : g_bad_words
      $error("WORD_W must exceed BYTE_W");
   end
   if (RELEASE_CLKS < 1) begin : g_bad_release
      $error("RELEASE_CLKS must be at least 1");
   end

   sd_op_e           op_in;
   logic             start_ok, is_rel, is_recv;
   logic             rel_r, pins_on, cs_hi;
   logic [BCW-1:0]   bits_left, bits_init;
   logic [WORD_W-1:0] load_word;
   logic             sck_hi, bit_end, last_bit, mosi_bit;

   assign op_in    = sd_op_e'(cmd_op);
   assign start_ok = cmd_start && !busy;
   assign is_rel   = (op_in == OP_RELEASE);
   assign is_recv  = (op_in == OP_RECV);
   assign last_bit = (bits_left == BCW'(1));

   always_comb begin
      if (is_rel || is_recv) load_word = '1;
      else if (cmd_long)     load_word = tx_word;
      else                   load_word = {tx_word[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b1}}};
      if (is_rel)        bits_init = BCW'(RELEASE_CLKS);
      else if (cmd_long) bits_init = BCW'(WORD_W);
      else               bits_init = BCW'(BYTE_W);
   end

   sdspi_phase_timer #(.SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(busy), .sck_hi(sck_hi), .bit_end(bit_end)
   );

   sdspi_shifter #(.MAX_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(start_ok), .load_word(load_word),
      .clr_rx(start_ok && !is_rel), .shift(bit_end), .cap_en(!rel_r),
      .miso(miso_i), .mosi_bit(mosi_bit), .rx_word(rx_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         done      <= 1'b0;
         rel_r     <= 1'b0;
         pins_on   <= 1'b0;
         cs_hi     <= 1'b1;
         bits_left <= '0;
      end else begin
         done <= bit_end && last_bit;
         if (start_ok) begin
            busy      <= 1'b1;
            rel_r     <= is_rel;
            pins_on   <= 1'b1;
            cs_hi     <= is_rel;
            bits_left <= bits_init;
         end else if (bit_end) begin
            bits_left <= bits_left - 1'b1;
            if (last_bit) begin
               busy <= 1'b0;
               if (rel_r) pins_on <= 1'b0;
            end
         end
      end
   end

   assign sclk_o  = sck_hi;
   assign mosi_o  = busy ? mosi_bit : 1'b1;
   assign csn_o   = cs_hi;
   assign sclk_oe = pins_on;
   assign mosi_oe = pins_on;
   assign csn_oe  = pins_on;

   p_idle_sck_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk_o);
   p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_busy_ends_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   p_cs_low_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rel_r) |-> (!csn_o && csn_oe));
   p_release_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rel_r) |-> (!sclk_oe && !mosi_oe && !csn_oe));
   p_release_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rel_r) |-> (mosi_o && csn_o));
endmodule

// File: tb/sdspi_link_tb.sv
`timescale 1ns/1ps
module sdspi_link_tb;
   localparam int S   = 2;
   localparam int H   = 3;
   localparam int REL = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic [1:0]  cmd_op = 2'd0;
   logic        cmd_long = 1'b0;
   logic [31:0] tx_word = '0;
   logic [31:0] rx_word;
   logic        done, busy, sclk_o, sclk_oe, mosi_o, mosi_oe, csn_o, csn_oe;
   logic        miso_i = 1'b0;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   sdspi_link #(.WORD_W(32), .BYTE_W(8), .SETUP_CYC(S), .HOLD_CYC(H),
                .RELEASE_CLKS(REL)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
      .cmd_long(cmd_long), .tx_word(tx_word), .rx_word(rx_word), .done(done),
      .busy(busy), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .mosi_o(mosi_o),
      .mosi_oe(mosi_oe), .miso_i(miso_i), .csn_o(csn_o), .csn_oe(csn_oe)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic oe_all(input logic v, input string req);
      chk(sclk_oe == v && mosi_oe == v && csn_oe == v, req, "output enables",
          {sclk_oe, mosi_oe, csn_oe}, {3{v}});
   endtask

   // one command, checked cycle by cycle; poke injects a start while busy
   task automatic run_op(input logic [1:0] op, input bit lng, input logic [31:0] tx,
                         input logic [31:0] reply, input bit poke);
      int nb;
      logic [31:0] prev_rx, exp_rx;
      logic exp_bit;
      nb = (op == 2'd2) ? REL : (lng ? 32 : 8);
      prev_rx = rx_word;
      @(negedge clk);
      cmd_start = 1'b1; cmd_op = op; cmd_long = lng; tx_word = tx;
      @(negedge clk);
      cmd_start = 1'b0;
      chk(busy == 1'b1, "R7", "busy after start", 32'(busy), 1);
      oe_all(1'b1, "R10");
      chk(csn_o == (op == 2'd2), "R10", "csn first cycle", 32'(csn_o), 32'(op == 2'd2));
      for (int b = 0; b < nb; b++) begin
         for (int c = 0; c < S + H; c++) begin
            if (c == 0) miso_i = (op == 2'd2) ? 1'b0 : reply[nb-1-b];
            if (op == 2'd0 || op == 2'd3) exp_bit = lng ? tx[31-b] : tx[7-b];
            else exp_bit = 1'b1;
            chk(sclk_o == (c >= S), "R3", "sclk phase", 32'(sclk_o), 32'(c >= S));
            chk(mosi_o == exp_bit, (op == 2'd0 || op == 2'd3) ? "R2" : (op == 2'd1 ? "R6" : "R9"),
                "mosi bit", 32'(mosi_o), 32'(exp_bit));
            chk(csn_o == (op == 2'd2) && csn_oe, (op == 2'd2) ? "R9" : "R8", "csn level",
                32'(csn_o), 32'(op == 2'd2));
            if (poke && b == 1 && c == 0) begin cmd_start = 1'b1; cmd_op = 2'd2; cmd_long = ~lng; end
            if (poke && b == 1 && c == 1) cmd_start = 1'b0;
            @(negedge clk);
         end
      end
      if (op == 2'd2) exp_rx = prev_rx;
      else if (lng) exp_rx = reply;
      else exp_rx = {24'h0, reply[7:0]};
      chk(done == 1'b1 && busy == 1'b0, "R7", "done/busy at end", {done, busy}, 2'b10);
      chk(sclk_o == 1'b0, "R3", "sclk low after", 32'(sclk_o), 0);
      chk(rx_word == exp_rx, (op == 2'd2) ? "R9" : (lng ? "R5" : "R4"), "rx_word", rx_word, exp_rx);
      if (op == 2'd2) oe_all(1'b0, "R9");
      @(negedge clk);
      chk(done == 1'b0, "R7", "done single pulse", 32'(done), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      oe_all(1'b0, "R1");
      chk(busy == 0 && done == 0, "R1", "busy/done in reset", {busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rx_word == 0, "R1", "rx after reset", rx_word, 0);
      oe_all(1'b0, "R1");

      for (int i = 0; i < 32; i++)
         run_op(2'd0, 1'b0, 32'((i * 37 + 5) & 8'hff), 32'(((i * 91) ^ 8'h3C) & 8'hff), 1'b0);
      for (int i = 0; i < 6; i++) begin
         logic [31:0] t, r;
         t = 32'h8000_0001 ^ (32'h1357_9BDF * i);
         r = 32'hA5A5_5A5A ^ (32'h0F0F_3C3C * i);
         run_op((i % 2 == 0) ? 2'd0 : 2'd3, 1'b1, t, r, 1'b0);
      end
      run_op(2'd0, 1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0);
      run_op(2'd0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0);
      // R6 receive-only
      run_op(2'd1, 1'b0, 32'h0000_0000, 32'h0000_0096, 1'b0);
      run_op(2'd1, 1'b1, 32'h1234_0000, 32'hDEAD_BEEF, 1'b0);
      // R4 upper tx bits ignored for a byte
      run_op(2'd0, 1'b0, 32'hFFFF_FF00, 32'h0000_0001, 1'b0);
      // R7 start while busy
      run_op(2'd0, 1'b0, 32'h0000_00C3, 32'h0000_005A, 1'b1);
      run_op(2'd0, 1'b1, 32'h7E81_18E7, 32'h0123_4567, 1'b1);
      // R8 idle between transfers
      repeat (4) begin
         @(negedge clk);
         chk(csn_o == 1'b0 && csn_oe == 1'b1, "R8", "idle csn", {csn_o, csn_oe}, 2'b01);
         chk(sclk_o == 1'b0, "R3", "idle sclk", 32'(sclk_o), 0);
      end
      // R9 release, then R10 stays floating
      run_op(2'd2, 1'b0, 32'h0000_0000, 32'h0, 1'b0);
      repeat (6) begin
         @(negedge clk);
         oe_all(1'b0, "R10");
      end
      run_op(2'd0, 1'b0, 32'h0000_0055, 32'h0000_00AA, 1'b0);
      run_op(2'd2, 1'b1, 32'h0, 32'h0, 1'b1);
      run_op(2'd1, 1'b1, 32'h0, 32'h8000_0000, 1'b0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule